// File: doc/BRIEF.md
# Bundled-Data Handshake Relay Chain

This block is a clocked, synthesizable model of a chain of single-rail bundled-data relay stages. Each stage holds one data word. A request wire runs forward alongside the data and an acknowledge wire runs backward. A stage takes a new word only when it has an unconsumed word offered from upstream and the stage after it has taken its previous word. That condition is a rendezvous of the incoming request and the inverted downstream acknowledge, modelled as a C-element that keeps its output until its two inputs agree.

A parameter selects the signalling discipline for the whole chain. In transition mode a level change in either direction on the request wire offers one word, and a level change on the acknowledge wire returns it. In return-to-zero mode a rising request offers a word, a rising acknowledge takes it, and both wires go back low before the next word. The chain is placed between a producer and a consumer that follow the same discipline. Each stage updates on the clock, so a word advances one stage per cycle when nothing blocks it.

Top module: `bdr_chain`

## Requirements
- R1: After reset is released, `in_ack` and `out_req` are 0 in both modes, and both stay 0 until the producer raises `in_req`.
- R2: In return-to-zero mode each delivered word makes exactly two transitions on `out_req`, one rise then one fall. The word on `out_data` changes only at the edge where `out_req` rises.
- R3: In transition mode each delivered word makes exactly one transition on `out_req`, rising or falling. The word on `out_data` changes only at an edge where `out_req` changes.
- R4: The sequence of words taken at the output equals the sequence offered at the input, with no loss, duplication or reordering, in both modes and under any producer and consumer pacing.
- R5: While a word is offered and not yet acknowledged, `out_data` holds its value. In transition mode this is when `out_req` differs from `out_ack`. In return-to-zero mode it is when `out_req` is 1 and `out_ack` is 0.
- R6: A stage output changes only in a cycle where its incoming request equals the inverse of the downstream acknowledge. With the consumer withholding its acknowledge, `out_req` and `out_data` stay unchanged however many words the producer offers.
- R7: With the producer idle and every word consumed, `out_req` and `in_ack` stay constant.
- R8: With the chain empty and the consumer ready, a word offered between clock edges appears at `out_req` on the NUM_STAGES-th rising edge after it is offered, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_req | input | 1 | Request from the producer |
| in_data | input | DATA_W | Word bundled with `in_req` |
| in_ack | output | 1 | Acknowledge to the producer |
| out_req | output | 1 | Request to the consumer |
| out_data | output | DATA_W | Word bundled with `out_req` |
| out_ack | input | 1 | Acknowledge from the consumer |

## Verification
The assertions assume that the neighbours obey the chosen discipline. The producer changes `in_req` only when `in_ack` shows that its previous word was taken, and holds `in_data` until then. The consumer changes `out_ack` only in reply to a pending request. The bench producer and consumer are written as handshake state machines that wait for the matching level before they drive anything, so every pacing pattern in the sweep stays inside these assumptions while the delays between steps change.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
   typedef enum logic {
      SIG_TRANSITION = 1'b0,
      SIG_RTZ        = 1'b1
   } sig_mode_e;
endpackage

// File: rtl/bdr_rendezvous.sv
module bdr_rendezvous (
   input  logic clk,
   input  logic rst_n,
   input  logic a_in,
   input  logic b_in,
   output logic c_out
);
   logic c_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         c_q <= 1'b0;
      else if (a_in == b_in)
         c_q <= a_in;
   end

   assign c_out = c_q;

   // R6
   hold_on_disagree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_in != b_in) |=> $stable(c_out));
endmodule

// File: rtl/bdr_stage.sv
module bdr_stage #(
   parameter int                  DATA_W = 32,
   parameter bdr_pkg::sig_mode_e  MODE   = bdr_pkg::SIG_TRANSITION
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_req,
   input  logic [DATA_W-1:0] up_data,
   output logic              up_ack,
   output logic              dn_req,
   output logic [DATA_W-1:0] dn_data,
   input  logic              dn_ack
);
   logic              phase;
   logic              fire;
   logic              load;
   logic [DATA_W-1:0] word_q;

   bdr_rendezvous meet_i (
      .clk   (clk),
      .rst_n (rst_n),
      .a_in  (up_req),
      .b_in  (~dn_ack),
      .c_out (phase)
   );

   // a step of the rendezvous happens this cycle
   assign fire = (up_req != phase) && (dn_ack == phase);

   generate
      if (MODE == bdr_pkg::SIG_RTZ) begin : g_rtz
         assign load = fire && up_req;
      end else begin : g_trans
         assign load = fire;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         word_q <= '0;
      else if (load)
         word_q <= up_data;
   end

   assign up_ack  = phase;
   assign dn_req  = phase;
   assign dn_data = word_q;

   // R5
   offer_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_req != dn_ack) |=> $stable(dn_data));

   // R1
   reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!dn_req && !up_ack));

   generate
      if (MODE == bdr_pkg::SIG_RTZ) begin : g_rtz_chk
         // R2
         rtz_load_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $changed(dn_data) |-> $rose(dn_req));
      end else begin : g_trans_chk
         // R3
         trans_load_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $changed(dn_data) |-> $changed(dn_req));
      end
   endgenerate
endmodule

// File: rtl/bdr_chain.sv
module bdr_chain #(
   parameter int                  DATA_W     = 32,
   parameter int                  NUM_STAGES = 4,
   parameter bdr_pkg::sig_mode_e  MODE       = bdr_pkg::SIG_TRANSITION
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_req,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ack,
   output logic              out_req,
   output logic [DATA_W-1:0] out_data,
   input  logic              out_ack
);
   localparam int LINKS = NUM_STAGES + 1;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("bdr_chain: DATA_W must be at least 1");
      end
      if (NUM_STAGES < 1) begin : g_bad_depth
         $error("bdr_chain: NUM_STAGES must be at least 1");
      end
   endgenerate

   // link k sits before stage k; link NUM_STAGES is the output side
   logic              req_l  [LINKS];
   logic              ack_l  [LINKS];
   logic [DATA_W-1:0] data_l [LINKS];

   assign req_l[0]          = in_req;
   assign data_l[0]         = in_data;
   assign in_ack            = ack_l[0];
   assign ack_l[NUM_STAGES] = out_ack;
   assign out_req           = req_l[NUM_STAGES];
   assign out_data          = data_l[NUM_STAGES];

   generate
      for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
         bdr_stage #(
            .DATA_W (DATA_W),
            .MODE   (MODE)
         ) stage_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .up_req  (req_l[s]),
            .up_data (data_l[s]),
            .up_ack  (ack_l[s]),
            .dn_req  (req_l[s+1]),
            .dn_data (data_l[s+1]),
            .dn_ack  (ack_l[s+1])
         );
      end
   endgenerate
endmodule

// File: tb/bdr_chain_tb_top.sv
module bdr_chain_tb_top;
   localparam int DW  = 32;
   localparam int NST = 4;
   localparam int WPP = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          up_req [2];
   logic [DW-1:0] up_dat [2];
   logic          up_ack [2];
   logic          dn_req [2];
   logic [DW-1:0] dn_dat [2];
   logic          dn_ack [2];

   int checks = 0;
   int errors = 0;
   int next_k [2];
   int edges  [2];
   int sent   [2];
   logic prev_req [2];

   bdr_chain #(.DATA_W(DW), .NUM_STAGES(NST), .MODE(bdr_pkg::SIG_TRANSITION)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .in_req(up_req[0]), .in_data(up_dat[0]), .in_ack(up_ack[0]),
      .out_req(dn_req[0]), .out_data(dn_dat[0]), .out_ack(dn_ack[0]));

   bdr_chain #(.DATA_W(DW), .NUM_STAGES(NST), .MODE(bdr_pkg::SIG_RTZ)) dut_rz_i (
      .clk(clk), .rst_n(rst_n),
      .in_req(up_req[1]), .in_data(up_dat[1]), .in_ack(up_ack[1]),
      .out_req(dn_req[1]), .out_data(dn_dat[1]), .out_ack(dn_ack[1]));

   function automatic logic [DW-1:0] word_of(input int m, input int k);
      return (32'(k + 1) * 32'h9E37_79B9) ^ (m != 0 ? 32'hA5A5_0000 : 32'h0);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // output transition counter
   always @(negedge clk) begin
      for (int m = 0; m < 2; m++) begin
         if (rst_n && dn_req[m] !== prev_req[m]) edges[m]++;
         prev_req[m] <= dn_req[m];
      end
   end

   task automatic produce(input int m, input int k0, input int cnt, input int p);
      for (int k = k0; k < k0 + cnt; k++) begin
         int d;
         d = (p == 1) ? (k * 3) % 4 : 0;
         repeat (d) @(negedge clk);
         if (m == 0) begin
            while (up_ack[0] !== up_req[0]) @(negedge clk);
            up_dat[0] = word_of(0, k);
            up_req[0] = ~up_req[0];
         end else begin
            while (up_ack[1] !== 1'b0) @(negedge clk);
            up_dat[1] = word_of(1, k);
            up_req[1] = 1'b1;
            while (up_ack[1] !== 1'b1) @(negedge clk);
            up_req[1] = 1'b0;
         end
         sent[m]++;
         @(negedge clk);
      end
   endtask

   task automatic consume(input int m, input int cnt, input int p);
      for (int j = 0; j < cnt; j++) begin
         logic [DW-1:0] got;
         int d;
         if (m == 0) while (dn_req[0] === dn_ack[0]) @(negedge clk);
         else        while (!(dn_req[1] === 1'b1 && dn_ack[1] === 1'b0)) @(negedge clk);
         got = dn_dat[m];
         // R4 order, no loss, no duplication
         chk(got === word_of(m, next_k[m]), "R4 word order", got, word_of(m, next_k[m]));
         d = (p == 0) ? 0 : (p == 1) ? (next_k[m] * 5 + 1) % 3 : next_k[m] % 7;
         repeat (d) @(negedge clk);
         if (d > 0)  // R5 offered word held until acknowledged
            chk(dn_dat[m] === got, "R5 offer stable", dn_dat[m], got);
         next_k[m]++;
         if (m == 0) dn_ack[0] = ~dn_ack[0];
         else begin
            dn_ack[1] = 1'b1;
            while (dn_req[1] !== 1'b0) @(negedge clk);
            dn_ack[1] = 1'b0;
         end
         @(negedge clk);
      end
   endtask

   task automatic run_mode(input int m);
      logic r0;
      int k;
      logic [DW-1:0] hd;
      // R8 latency through an empty chain
      @(negedge clk);
      r0 = dn_req[m];
      up_dat[m] = word_of(m, 0);
      up_req[m] = ~up_req[m];
      repeat (NST - 1) @(posedge clk);
      @(negedge clk);
      chk(dn_req[m] === r0, "R8 not before N edges", DW'(dn_req[m]), DW'(r0));
      @(posedge clk);
      @(negedge clk);
      chk(dn_req[m] === ~r0, "R8 arrives at N edges", DW'(dn_req[m]), DW'(~r0));
      if (m == 1) begin
         while (up_ack[1] !== 1'b1) @(negedge clk);
         up_req[1] = 1'b0;
      end
      sent[m] = 1;
      consume(m, 1, 0);
      k = 1;
      for (int p = 0; p < 3; p++) begin
         fork
            produce(m, k, WPP, p);
            consume(m, WPP, p);
         join
         k += WPP;
      end
      // R6 stalled consumer freezes the output
      fork
         produce(m, k, 3, 0);
         begin
            if (m == 0) while (dn_req[0] === dn_ack[0]) @(negedge clk);
            else        while (dn_req[1] !== 1'b1) @(negedge clk);
            r0 = dn_req[m];
            hd = dn_dat[m];
            repeat (20) @(negedge clk);
            chk(dn_req[m] === r0, "R6 stall req held", DW'(dn_req[m]), DW'(r0));
            chk(dn_dat[m] === hd, "R6 stall data held", dn_dat[m], hd);
            consume(m, 3, 0);
         end
      join
      // R7 idle chain stays quiet
      r0 = dn_req[m];
      hd = DW'(up_ack[m]);
      repeat (30) @(negedge clk);
      chk(dn_req[m] === r0, "R7 idle out_req", DW'(dn_req[m]), DW'(r0));
      chk(DW'(up_ack[m]) === hd, "R7 idle in_ack", DW'(up_ack[m]), hd);
      chk(next_k[m] == sent[m], "R4 count", DW'(next_k[m]), DW'(sent[m]));
      if (m == 0)  // R3 one transition per word
         chk(edges[0] == sent[0], "R3 edges per word", DW'(edges[0]), DW'(sent[0]));
      else         // R2 two transitions per word
         chk(edges[1] == 2 * sent[1], "R2 edges per word", DW'(edges[1]), DW'(2 * sent[1]));
   endtask

   initial begin
      for (int m = 0; m < 2; m++) begin
         up_req[m] = 1'b0; up_dat[m] = '0; dn_ack[m] = 1'b0;
         next_k[m] = 0; edges[m] = 0; sent[m] = 0; prev_req[m] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      for (int m = 0; m < 2; m++) begin
         // R1 idle after reset
         chk(up_ack[m] === 1'b0, "R1 in_ack reset", DW'(up_ack[m]), '0);
         chk(dn_req[m] === 1'b0, "R1 out_req reset", DW'(dn_req[m]), '0);
      end
      run_mode(0);
      run_mode(1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule